// File: doc/BRIEF.md
# BCD real-time calendar counter

This block keeps wall-clock time and calendar date for a chip that has a slow reference enable, nominally one pulse per period of a 32.768 kHz crystal. A prescaler counts those pulses and produces one tick per second. The tick advances a cascade of packed-BCD fields: seconds, minutes, hours, date, month, day-of-week and a two-digit year. The hours field works either as a 12-hour clock with a PM flag or as a 24-hour clock. The date wraps at the true end of each month, and February gets a 29th day in leap years.

A host-side interface, which lives outside this block, loads any field through a single-cycle write port. It reads any of eight registers through a combinational read port. Seconds bit 7 stops the clock. A control register carries a write-protect bit that locks the seven time and date registers.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the registers read seconds 0x80 (halted), minutes 0x00, hours 0x00, date 0x01, month 0x01, day 0x01, year 0x00 and control 0x00.
- R2: While not halted, each run of PRESCALE cycles with ref_tick high produces one seconds step. Seconds count 00..59 in BCD and wrap to 00. Each wrap steps minutes, which also count 00..59.
- R3: With hours bit 7 = 0 (24-hour), hours bits 5:0 count BCD 00..23. The step from 23 goes to 00 and advances the date.
- R4: With hours bit 7 = 1 (12-hour), bits 4:0 hold BCD 01..12 and bit 5 is PM (1 = PM). The step from 11 goes to 12 and inverts bit 5. The step from 12 goes to 01 and leaves bit 5 unchanged. The date advances only on the step from 11 PM to 12 AM.
- R5: On a date advance, the date returns to 01 and the month steps when the date is at or above the month's last day: 30 for months 04, 06, 09 and 11, and 31 for the other months except 02.
- R6: February ends on 29 when the BCD year read as a decimal number is divisible by 4, year 00 included. In all other years it ends on 28.
- R7: The day field (1..7) steps on every date advance and goes from 7 to 1. The step from month 12 goes to 01 and advances the year. The year counts 00..99 and wraps to 00.
- R8: While seconds bit 7 is 1, no field counts and the prescaler holds its count. Writing seconds with bit 7 = 0 resumes counting.
- R9: An accepted write to seconds clears the prescaler, so the next seconds step comes PRESCALE enabled cycles later. A write to a field wins over a count step of that field in the same cycle.
- R10: While control bit 7 (write-protect) is 1, writes to addresses 0..6 have no effect. The control register is always writable. Control bits 6:0 read 0.
- R11: rd_data shows the register at rd_addr in the same cycle, in the order 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day, 6 year, 7 control. Bits that are not stored read 0: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5 and day bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference enable, one cycle per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |

## Verification
Directed runs place the clock just before each rollover boundary and then let it run through that boundary. The boundaries are midnight in 24-hour mode, the 11-to-12 and 12-to-01 steps in both halves of the 12-hour day, the ends of 30-day and 31-day months, February in a leap year, a non-leap year and year 00, and the turn of the century. These runs separate a wrong month-length table, a wrong leap rule and a PM toggle placed on the wrong hour. Other runs cover halting, write-protect and writes to seconds in the middle of a count; they separate a prescaler that is not cleared or keeps running while halted. A long random phase mixes valid field writes, random reference gaps and write-protect toggles. A bench model compares all eight registers after every cycle, so an error in carry timing or in write priority shows up in the cycle where it happens.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) bcd_inc = {v[7:4] + 4'h1, 4'h0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'h1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] rem;
    rem = {yr[4], 1'b0} + yr[1:0];
    is_leap = (rem == 2'd0);
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      month_last = is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic halt,
  input  logic clr,
  output logic sec_pulse
);
  localparam int CW = $clog2(PRESCALE);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last      = (cnt_q == CW'(PRESCALE - 1));
  assign sec_pulse = ref_tick & ~halt & ~clr & last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                   cnt_d = '0;
    else if (ref_tick && !halt) cnt_d = last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rtc_clock.sv
module rtc_clock
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_pulse,
  input  logic [2:0] wsel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_q,
  output logic [7:0] min_q,
  output logic [7:0] hr_q,
  output logic       hr_step,
  output logic       day_carry
);
  logic [7:0] sec_d, min_d, hr_d, h12_inc, h24_inc;
  logic       sec_wrap, min_wrap, min_step, mode12;

  assign sec_wrap  = (sec_q[6:0] == 7'h59);
  assign min_wrap  = (min_q[6:0] == 7'h59);
  assign min_step  = sec_pulse & sec_wrap;
  assign hr_step   = min_step & min_wrap;
  assign mode12    = hr_q[7];
  assign h12_inc   = bcd_inc({3'b000, hr_q[4:0]});
  assign h24_inc   = bcd_inc({2'b00, hr_q[5:0]});
  assign day_carry = hr_step & (mode12 ? (hr_q[4:0] == 5'h11 && hr_q[5])
                                       : (hr_q[5:0] == 6'h23));

  always_comb begin
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    if (sec_pulse) sec_d = {sec_q[7], sec_wrap ? 7'h00 : bcd_inc({1'b0, sec_q[6:0]})[6:0]};
    if (min_step)  min_d = min_wrap ? 8'h00 : bcd_inc(min_q);
    if (hr_step) begin
      if (mode12) begin
        if (hr_q[4:0] == 5'h11)      hr_d = {2'b10, ~hr_q[5], 5'h12};
        else if (hr_q[4:0] == 5'h12) hr_d = {2'b10, hr_q[5], 5'h01};
        else                         hr_d = {2'b10, hr_q[5], h12_inc[4:0]};
      end else begin
        hr_d = (hr_q[5:0] == 6'h23) ? 8'h00 : {2'b00, h24_inc[5:0]};
      end
    end
    if (wsel[0]) sec_d = wr_data;
    if (wsel[1]) min_d = wr_data & 8'h7F;
    if (wsel[2]) hr_d  = wr_data & 8'hBF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 8'h80;
      min_q <= 8'h00;
      hr_q  <= 8'h00;
    end else begin
      sec_q <= sec_d;
      min_q <= min_d;
      hr_q  <= hr_d;
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_carry,
  input  logic [3:0] wsel,
  input  logic [7:0] wr_data,
  output logic [7:0] date_q,
  output logic [7:0] mon_q,
  output logic [7:0] dow_q,
  output logic [7:0] yr_q
);
  logic [7:0] date_d, mon_d, dow_d, yr_d;
  logic       date_end, mon_end, mon_step, yr_step;

  assign date_end = (date_q >= month_last(mon_q, yr_q));
  assign mon_end  = (mon_q >= 8'h12);
  assign mon_step = day_carry & date_end;
  assign yr_step  = mon_step & mon_end;

  always_comb begin
    date_d = date_q;
    mon_d  = mon_q;
    dow_d  = dow_q;
    yr_d   = yr_q;
    if (day_carry) begin
      date_d = date_end ? 8'h01 : bcd_inc(date_q);
      dow_d  = (dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01;
    end
    if (mon_step) mon_d = mon_end ? 8'h01 : bcd_inc(mon_q);
    if (yr_step)  yr_d  = (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
    if (wsel[0]) date_d = wr_data & 8'h3F;
    if (wsel[1]) mon_d  = wr_data & 8'h1F;
    if (wsel[2]) dow_d  = wr_data & 8'h07;
    if (wsel[3]) yr_d   = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      dow_q  <= 8'h01;
      yr_q   <= 8'h00;
    end else begin
      date_q <= date_d;
      mon_q  <= mon_d;
      dow_q  <= dow_d;
      yr_q   <= yr_d;
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int PRESCALE = 32768,
  parameter int NREG     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data
);
  localparam logic [2:0] CTRL_ADDR = 3'(NREG - 1);

  logic [1:0]      rst_pipe;
  logic            rst_n_s;
  logic            wr_ok, sec_pulse, hr_step, day_carry, wp_q, wp_d;
  logic [NREG-1:0] wsel;
  logic [7:0]      sec_q, min_q, hr_q, date_q, mon_q, dow_q, yr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  assign wr_ok = wr_en & (~wp_q | (wr_addr == CTRL_ADDR));

  for (genvar i = 0; i < NREG; i++) begin : g_wsel
    assign wsel[i] = wr_ok & (wr_addr == 3'(i));
  end

  assign wp_d = wsel[NREG-1] ? wr_data[7] : wp_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) wp_q <= 1'b0;
    else          wp_q <= wp_d;
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) i_presc (
    .clk(clk), .rst_n(rst_n_s), .ref_tick(ref_tick), .halt(sec_q[7]),
    .clr(wsel[0]), .sec_pulse(sec_pulse)
  );

  rtc_clock i_clock (
    .clk(clk), .rst_n(rst_n_s), .sec_pulse(sec_pulse), .wsel(wsel[2:0]),
    .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q),
    .hr_step(hr_step), .day_carry(day_carry)
  );

  rtc_calendar i_cal (
    .clk(clk), .rst_n(rst_n_s), .day_carry(day_carry), .wsel(wsel[6:3]),
    .wr_data(wr_data), .date_q(date_q), .mon_q(mon_q), .dow_q(dow_q), .yr_q(yr_q)
  );

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = sec_q;
      3'd1:    rd_data = min_q;
      3'd2:    rd_data = hr_q;
      3'd3:    rd_data = date_q;
      3'd4:    rd_data = mon_q;
      3'd5:    rd_data = dow_q;
      3'd6:    rd_data = yr_q;
      default: rd_data = {wp_q, 7'b0};
    endcase
  end
endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sec_pulse,
  input logic       hr_step,
  input logic       day_carry,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hr_q,
  input logic [7:0] dow_q,
  input logic       wp_q
);
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && sec_q[6:0] == 7'h59 |=> sec_q[6:0] == 7'h00);

  a_r8_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[7] && !wr_en |=> $stable(sec_q) && $stable(min_q) && $stable(hr_q));

  a_r10_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q && wr_en && wr_addr == 3'd1 && !sec_pulse |=> $stable(min_q));

  a_r7_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    day_carry && dow_q == 8'h07 && !(wr_en && wr_addr == 3'd5) |=> dow_q == 8'h01);

  a_r3_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    hr_step && !hr_q[7] && hr_q[5:0] == 6'h23 && !(wr_en && wr_addr == 3'd2)
    |=> hr_q == 8'h00);

  a_r4_pm_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    hr_step && hr_q[7] && hr_q[4:0] == 5'h11 && !(wr_en && wr_addr == 3'd2)
    |=> hr_q[4:0] == 5'h12 && hr_q[5] != $past(hr_q[5]));
endmodule

bind bcd_rtc_core rtc_core_chk i_chk (
  .clk(clk), .rst_n(rst_n_s), .sec_pulse(sec_pulse), .hr_step(hr_step),
  .day_carry(day_carry), .wr_en(wr_en), .wr_addr(wr_addr), .sec_q(sec_q),
  .min_q(min_q), .hr_q(hr_q), .dow_q(dow_q), .wp_q(wp_q)
);

// File: tb/test_bcd_rtc_core.sv
`timescale 1ns/100ps
module test_bcd_rtc_core;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [2:0] rd_addr = 3'd0;
  logic [7:0] rd_data;

  int    n_chk = 0, n_bad = 0, presc = 0;
  bit    done = 1'b0;
  string tag = "R1";
  logic [7:0] m [8];

  always #2 clk = ~clk;

  bcd_rtc_core #(.PRESCALE(P)) i_bcd_rtc_core (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int b2i(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic logic [7:0] wmask(input int a);
    case (a)
      1: return 8'h7F;  2: return 8'hBF;  3: return 8'h3F;
      4: return 8'h1F;  5: return 8'h07;  7: return 8'h80;
      default: return 8'hFF;
    endcase
  endfunction
  function automatic int days_in(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model(input bit we, input int a, input logic [7:0] d, input bit tr);
    logic [7:0] n [8];
    bit wok, tick, cm, ch, cd, cmo, pm;
    int s, mi, h, dt, mo, yr;
    n = m;
    wok  = we && (!m[7][7] || a == 7);
    tick = tr && !m[0][7] && presc == P - 1 && !(wok && a == 0);
    if (wok && a == 0)           presc = 0;
    else if (tr && !m[0][7])     presc = (presc == P - 1) ? 0 : presc + 1;
    cm = 0; ch = 0; cd = 0; cmo = 0;
    if (tick) begin
      s = b2i({1'b0, m[0][6:0]});
      if (s < 59) s++; else begin s = 0; cm = 1; end
      n[0] = {m[0][7], i2b(s)[6:0]};
      if (cm) begin
        mi = b2i(m[1]);
        if (mi < 59) mi++; else begin mi = 0; ch = 1; end
        n[1] = i2b(mi);
      end
      if (ch) begin
        if (m[2][7]) begin
          h = b2i({3'b0, m[2][4:0]}); pm = m[2][5];
          if (h == 11) begin h = 12; cd = pm; pm = ~pm; end
          else if (h == 12) h = 1;
          else h++;
          n[2] = {2'b10, pm, i2b(h)[4:0]};
        end else begin
          h = b2i({2'b0, m[2][5:0]});
          if (h == 23) begin h = 0; cd = 1; end else h++;
          n[2] = i2b(h);
        end
      end
      if (cd) begin
        n[5] = (m[5] == 8'h07) ? 8'h01 : m[5] + 8'h01;
        dt = b2i(m[3]); mo = b2i(m[4]); yr = b2i(m[6]);
        if (dt < days_in(mo, yr)) dt++; else begin dt = 1; cmo = 1; end
        n[3] = i2b(dt);
        if (cmo) begin
          if (mo == 12) begin mo = 1; n[6] = i2b((yr + 1) % 100); end
          else mo++;
          n[4] = i2b(mo);
        end
      end
    end
    if (wok) n[a] = d & wmask(a);
    m = n;
  endtask

  task automatic check_all();
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #0.1;
      n_chk++;
      if (rd_data !== m[a]) begin
        n_bad++;
        $display("FAIL %s reg %0d: got %h expected %h at %0t", tag, a, rd_data, m[a], $time);
      end
    end
  endtask

  task automatic step(input bit we, input int a, input logic [7:0] d, input bit tr);
    wr_en = we; wr_addr = 3'(a); wr_data = d; ref_tick = tr;
    @(posedge clk);
    model(we, a, d, tr);
    #1;
    check_all();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 8'h00, 1'b1);
  endtask

  task automatic set_all(input logic [7:0] hr, input logic [7:0] dt, input logic [7:0] mo,
                         input logic [7:0] dw, input logic [7:0] yr, input logic [7:0] mi,
                         input logic [7:0] sc);
    wr(2, hr); wr(3, dt); wr(4, mo); wr(5, dw); wr(6, yr); wr(1, mi); wr(0, sc);
  endtask

  function automatic logic [7:0] rand_val(input int a);
    int h;
    case (a)
      0: return {($urandom_range(3) == 0), i2b($urandom_range(59))[6:0]};
      1: return i2b($urandom_range(59));
      2: if ($urandom_range(1) == 1) begin
           h = $urandom_range(12, 1);
           return {2'b10, 1'($urandom_range(1)), i2b(h)[4:0]};
         end else return i2b($urandom_range(23));
      3: return i2b($urandom_range(31, 1));
      4: return i2b($urandom_range(12, 1));
      5: return i2b($urandom_range(7, 1));
      6: return i2b($urandom_range(99));
      default: return ($urandom_range(3) == 0) ? 8'h80 : 8'h00;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m = '{8'h80, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 0, 8'h00, 1'b0);

    tag = "R8";
    run(12);
    tag = "R10";
    wr(7, 8'h80); wr(1, 8'h33); wr(0, 8'h10); wr(7, 8'hFF); wr(7, 8'h00);

    tag = "R3";
    set_all(8'h23, 8'h28, 8'h02, 8'h03, 8'h23, 8'h59, 8'h58); run(3 * P);
    tag = "R6";
    set_all(8'h23, 8'h28, 8'h02, 8'h04, 8'h24, 8'h59, 8'h58); run(3 * P);
    run(P * 0 + 1);
    set_all(8'h23, 8'h29, 8'h02, 8'h05, 8'h24, 8'h59, 8'h58); run(3 * P);
    set_all(8'h23, 8'h28, 8'h02, 8'h06, 8'h00, 8'h59, 8'h58); run(3 * P);
    tag = "R5";
    set_all(8'h23, 8'h30, 8'h04, 8'h02, 8'h11, 8'h59, 8'h58); run(3 * P);
    set_all(8'h23, 8'h30, 8'h05, 8'h02, 8'h11, 8'h59, 8'h58); run(3 * P);
    tag = "R7";
    set_all(8'h23, 8'h31, 8'h12, 8'h07, 8'h99, 8'h59, 8'h58); run(3 * P);
    tag = "R4";
    set_all(8'h91, 8'h10, 8'h03, 8'h02, 8'h20, 8'h59, 8'h58); run(3 * P);
    set_all(8'hB2, 8'h10, 8'h03, 8'h02, 8'h20, 8'h59, 8'h58); run(3 * P);
    set_all(8'hB1, 8'h31, 8'h03, 8'h07, 8'h20, 8'h59, 8'h58); run(3 * P);
    tag = "R2";
    set_all(8'h05, 8'h10, 8'h03, 8'h02, 8'h20, 8'h00, 8'h00); run(70 * P);
    tag = "R9";
    run(2); wr(0, 8'h30); run(P + 1); step(1'b1, 0, 8'h40, 1'b1); run(2 * P);
    tag = "R8";
    wr(0, 8'h85); run(3 * P); wr(0, 8'h05); run(2 * P);

    tag = "R2 R9 R10 R11";
    for (int i = 0; i < 6000; i++) begin
      int a;
      a = $urandom_range(7);
      if ($urandom_range(7) == 0) step(1'b1, a, rand_val(a), $urandom_range(3) != 0);
      else                        step(1'b0, 0, 8'h00, $urandom_range(3) != 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule